// File: doc/BRIEF.md
# NAND Flash Bus Timing Sequencer

This block turns single-cycle host requests into properly timed cycles on a raw NAND flash bus of 8 or 16 bits. The host has four separate request inputs: command byte, address byte, data write and data read. A request is accepted when the block reports it is ready. For each accepted request the block lowers chip enable and produces the latch enables, the write and read strobes and the output enable of the data bus. A read returns its data with a one-cycle valid pulse.

Every access runs through programmable phases. A setup phase comes before the strobe and a wait phase holds the strobe low. A hold phase follows, in which the strobe is high again. Two optional lead-in phases can come first. A read that follows a command or an address gets an extra latch-to-read delay. An access that drives the bus after a read gets a bus-turnaround gap. All counts come from two 32-bit configuration registers written through a small write port. The block can also hold off new accesses while the flash reports busy.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high (inactive), both latch enables and the bus output enable are low, and `req_ready` is low. Requests are only accepted while control bit 2 (enable) and control bit 3 (NAND select) are both 1 and control bit 0 (soft reset) is 0. Configuration port `cfg_sel` 0 writes the control register and 1 writes the timing register.
- R2: The setup phase lasts (timing bits 7:0) + 1 cycles. In it chip enable is low and both strobes are high. Command, address and write accesses drive the bus and assert their latch enable from this phase on.
- R3: The wait phase lasts (timing bits 15:8) + 1 cycles. In it the write strobe is low for command, address and write accesses, and the read strobe is low for reads.
- R4: The hold phase lasts (timing bits 23:16) cycles, with a value of 0 taken as 1. In it both strobes are high while the latch enable and the driven data stay as they were. Chip enable then rises for at least one idle cycle before the next access.
- R5: A command asserts CLE and puts its byte on `nand_dq_out[7:0]`. An address asserts ALE in the same way. A write drives its data with neither latch enable. When several requests are valid in the same cycle, only one is taken, in the priority order command, address, write, read.
- R6: A read that directly follows a command starts with (control bits 12:9) + 1 extra cycles. A read that directly follows an address starts with (control bits 16:13) + 1 extra cycles. In these cycles chip enable is low, both latch enables and the output enable are low, and the read strobe is high.
- R7: A command, address or write that directly follows a read starts with (timing bits 31:24) cycles in which chip enable is low and the bus output enable stays low. A value of 0 gives no such cycles.
- R8: Read data is sampled from `nand_dq_in` on the clock edge that ends the wait phase, where the read strobe rises. `rd_valid` pulses for exactly one cycle, two edges after that sampling edge, with the sampled value on `rd_data`.
- R9: With control bit 4 (wide) at 0, only the low byte is driven (`nand_dq_out[15:8]` is 0) and only the low byte is returned (`rd_data[15:8]` is 0). With it at 1, all 16 bits are used.
- R10: With control bit 1 (wait enable) at 1, no new access starts while the synchronised `nand_rb` is low. The synchronisation delay is two clock edges. With the bit at 0, `nand_rb` has no effect.
- R11: Clearing the enable bit or the NAND-select bit aborts any access in progress. Chip enable is high from the second edge after the register write and stays high, with `req_ready` low.
- R12: While the soft reset bit is 1, the sequencer stays idle and accepts nothing. The soft reset also clears the record of the previous access type, so the next read gets no latch-to-read delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | 0 selects the control register, 1 the timing register |
| cfg_wdata | input | 32 | Configuration write data |
| cmd_valid | input | 1 | Command byte request |
| cmd_byte | input | 8 | Command opcode |
| addr_valid | input | 1 | Address byte request |
| addr_byte | input | 8 | Address byte |
| wr_valid | input | 1 | Data write request |
| wr_data | input | 16 | Data to write |
| rd_req | input | 1 | Data read request |
| req_ready | output | 1 | A request is accepted this cycle if one is valid |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds read data |
| rd_data | output | 16 | Data returned by a read |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data bus drive value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 16 | Data bus sampled value |
| nand_rb | input | 1 | Ready/busy from the flash, high when ready |

## Verification
The assertions check, on every cycle, these bus rules:
- The two strobes are never low together.
- The bus is never driven while the read strobe is low.
- A latch enable is only high while chip enable is low.
- Written data holds steady through the write strobe.
- Every read sample is followed by its valid pulse exactly two edges later, and every valid pulse has a sample behind it.
- Chip enable cannot fall while the block is not ready, so it stays high whenever the bank is disabled.

Only the bench's scenarios can show the phase lengths and the lead-in phases that depend on the previous access. The same holds for request priority, byte-width masking, the busy stall and the soft reset clearing the history. The bench measures each access from the pins and compares it against a record it builds from the programmed fields.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

  localparam int REG_W = 32;
  localparam int TF_W  = 8;
  localparam int DF_W  = 4;
  localparam int CNT_W = TF_W + 1;

  typedef enum logic [2:0] {K_NONE, K_CMD, K_ADDR, K_WR, K_RD} kind_e;
  typedef enum logic [2:0] {PH_IDLE, PH_HIZ, PH_TURN, PH_SETUP, PH_WAIT, PH_HOLD} phase_e;

  typedef struct packed {
    logic            soft_rst;
    logic            wait_en;
    logic            enable;
    logic            nand_sel;
    logic            wide;
    logic [DF_W-1:0] cle_dly;
    logic [DF_W-1:0] ale_dly;
  } ctrl_t;

  typedef struct packed {
    logic [TF_W-1:0] hiz;
    logic [TF_W-1:0] hold;
    logic [TF_W-1:0] wt;
    logic [TF_W-1:0] setup;
  } tim_t;

  function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] r);
    ctrl_t c;
    c.soft_rst = r[0];
    c.wait_en  = r[1];
    c.enable   = r[2];
    c.nand_sel = r[3];
    c.wide     = r[4];
    c.cle_dly  = r[12:9];
    c.ale_dly  = r[16:13];
    return c;
  endfunction

  function automatic tim_t unpack_tim(input logic [REG_W-1:0] r);
    tim_t t;
    t.setup = r[7:0];
    t.wt    = r[15:8];
    t.hold  = r[23:16];
    t.hiz   = r[31:24];
    return t;
  endfunction

  // Number of cycles a phase occupies; zero means the phase is skipped.
  function automatic logic [CNT_W-1:0] phase_cycles(input phase_e p, input kind_e k,
                                                    input kind_e prior, input ctrl_t c,
                                                    input tim_t t);
    logic [CNT_W-1:0] n;
    n = '0;
    case (p)
      PH_HIZ:   if (k != K_RD && prior == K_RD) n = CNT_W'(t.hiz);
      PH_TURN: begin
        if (k == K_RD && prior == K_CMD)  n = CNT_W'(c.cle_dly) + CNT_W'(1);
        if (k == K_RD && prior == K_ADDR) n = CNT_W'(c.ale_dly) + CNT_W'(1);
      end
      PH_SETUP: n = CNT_W'(t.setup) + CNT_W'(1);
      PH_WAIT:  n = CNT_W'(t.wt) + CNT_W'(1);
      PH_HOLD:  n = (t.hold == '0) ? CNT_W'(1) : CNT_W'(t.hold);
      default:  n = '0;
    endcase
    return n;
  endfunction

  function automatic phase_e step_phase(input phase_e p);
    case (p)
      PH_IDLE:  return PH_HIZ;
      PH_HIZ:   return PH_TURN;
      PH_TURN:  return PH_SETUP;
      PH_SETUP: return PH_WAIT;
      PH_WAIT:  return PH_HOLD;
      default:  return PH_IDLE;
    endcase
  endfunction

  // Next phase that actually takes cycles (setup, wait and hold never skip).
  function automatic phase_e next_phase(input phase_e p, input kind_e k, input kind_e prior,
                                        input ctrl_t c, input tim_t t);
    phase_e q;
    q = step_phase(p);
    if (q == PH_HIZ && phase_cycles(q, k, prior, c, t) == '0)  q = step_phase(q);
    if (q == PH_TURN && phase_cycles(q, k, prior, c, t) == '0) q = step_phase(q);
    return q;
  endfunction

endpackage

// File: rtl/nbs_cfg_regs.sv
module nbs_cfg_regs
  import nbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output ctrl_t            ctrl,
  output tim_t             tim
);

  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] tim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tim_q  <= '0;
    end else if (cfg_wr) begin
      if (cfg_sel) tim_q  <= cfg_wdata;
      else         ctrl_q <= cfg_wdata;
    end
  end

  assign ctrl = unpack_ctrl(ctrl_q);
  assign tim  = unpack_tim(tim_q);

endmodule

// File: rtl/nbs_rb_sync.sv
module nbs_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_in,
  output logic rb_out
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign rb_out = rb_in;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)      sr[i] <= 1'b1;
          else if (i == 0) sr[i] <= rb_in;
          else             sr[i] <= sr[(i == 0) ? 0 : i-1];
        end
      end
      assign rb_out = sr[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/nbs_phase_seq.sv
module nbs_phase_seq
  import nbs_pkg::*;
#(
  parameter int DQ_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  tim_t              tim,
  input  logic              rb_ok,
  input  logic              cmd_valid,
  input  logic [DQ_W/2-1:0] cmd_byte,
  input  logic              addr_valid,
  input  logic [DQ_W/2-1:0] addr_byte,
  input  logic              wr_valid,
  input  logic [DQ_W-1:0]   wr_data,
  input  logic              rd_req,
  output phase_e            phase,
  output kind_e             kind,
  output logic [DQ_W-1:0]   data,
  output logic              ready,
  output logic              bank_active,
  output logic              cap_evt
);

  localparam int BYTE_W = DQ_W / 2;

  logic [CNT_W-1:0] cnt_q;
  kind_e            prior_q;
  kind_e            sel_kind;
  logic [DQ_W-1:0]  sel_data;
  logic             accept;
  phase_e           nxt;

  assign bank_active = ctrl.enable && ctrl.nand_sel && !ctrl.soft_rst;
  assign ready       = bank_active && (phase == PH_IDLE) && (!ctrl.wait_en || rb_ok);

  // Fixed request priority: command, address, write, read.
  always_comb begin
    sel_kind = K_NONE;
    sel_data = '0;
    if (cmd_valid) begin
      sel_kind = K_CMD;
      sel_data = {{BYTE_W{1'b0}}, cmd_byte};
    end else if (addr_valid) begin
      sel_kind = K_ADDR;
      sel_data = {{BYTE_W{1'b0}}, addr_byte};
    end else if (wr_valid) begin
      sel_kind = K_WR;
      sel_data = ctrl.wide ? wr_data : {{BYTE_W{1'b0}}, wr_data[BYTE_W-1:0]};
    end else if (rd_req) begin
      sel_kind = K_RD;
    end
  end

  assign accept = ready && (sel_kind != K_NONE);

  always_comb begin
    if (phase == PH_IDLE) nxt = next_phase(PH_IDLE, sel_kind, prior_q, ctrl, tim);
    else                  nxt = next_phase(phase, kind, prior_q, ctrl, tim);
  end

  assign cap_evt = bank_active && (phase == PH_WAIT) && (kind == K_RD) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      kind    <= K_NONE;
      data    <= '0;
      cnt_q   <= '0;
      prior_q <= K_NONE;
    end else if (!bank_active) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
      if (ctrl.soft_rst) prior_q <= K_NONE;
    end else if (phase == PH_IDLE) begin
      if (accept) begin
        kind    <= sel_kind;
        data    <= sel_data;
        prior_q <= sel_kind;
        phase   <= nxt;
        cnt_q   <= phase_cycles(nxt, sel_kind, prior_q, ctrl, tim) - CNT_W'(1);
      end
    end else if (cnt_q == '0) begin
      phase <= nxt;
      cnt_q <= (nxt == PH_IDLE) ? '0 : phase_cycles(nxt, kind, prior_q, ctrl, tim) - CNT_W'(1);
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nbs_pkg::*;
#(
  parameter int DQ_W    = 16,
  parameter int RB_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              cmd_valid,
  input  logic [DQ_W/2-1:0] cmd_byte,
  input  logic              addr_valid,
  input  logic [DQ_W/2-1:0] addr_byte,
  input  logic              wr_valid,
  input  logic [DQ_W-1:0]   wr_data,
  input  logic              rd_req,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DQ_W-1:0]   nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DQ_W-1:0]   nand_dq_in,
  input  logic              nand_rb
);

  localparam int BYTE_W = DQ_W / 2;

  ctrl_t           ctrl;
  tim_t            tim;
  logic            rb_ok;
  phase_e          phase;
  kind_e           kind;
  logic [DQ_W-1:0] data;
  logic            bank_active;
  logic            cap_evt;
  logic            on_bus;
  logic            strobe;
  logic            cap_q;

  nbs_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctrl(ctrl), .tim(tim)
  );

  nbs_rb_sync #(.STAGES(RB_SYNC)) u_rb (
    .clk(clk), .rst_n(rst_n), .rb_in(nand_rb), .rb_out(rb_ok)
  );

  nbs_phase_seq #(.DQ_W(DQ_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .tim(tim), .rb_ok(rb_ok),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .addr_valid(addr_valid), .addr_byte(addr_byte),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .phase(phase), .kind(kind), .data(data), .ready(req_ready),
    .bank_active(bank_active), .cap_evt(cap_evt)
  );

  assign on_bus      = (phase == PH_SETUP) || (phase == PH_WAIT) || (phase == PH_HOLD);
  assign strobe      = (phase == PH_WAIT);
  assign nand_ce_n   = (phase == PH_IDLE);
  assign nand_cle    = on_bus && (kind == K_CMD);
  assign nand_ale    = on_bus && (kind == K_ADDR);
  assign nand_we_n   = !(strobe && kind != K_RD);
  assign nand_re_n   = !(strobe && kind == K_RD);
  assign nand_dq_oe  = on_bus && (kind != K_RD);
  assign nand_dq_out = data;

  // Sample at the edge where the read strobe rises, flag valid one cycle later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      cap_q    <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      if (cap_evt)
        rd_data <= ctrl.wide ? nand_dq_in : {{BYTE_W{1'b0}}, nand_dq_in[BYTE_W-1:0]};
      cap_q    <= cap_evt;
      rd_valid <= cap_q;
    end
  end

endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
  parameter int DQ_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ce_n,
  input logic            cle,
  input logic            ale,
  input logic            we_n,
  input logic            re_n,
  input logic            dq_oe,
  input logic [DQ_W-1:0] dq_out,
  input logic            req_ready,
  input logic            rd_valid,
  input logic            cap_evt,
  input logic            bank_active
);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) (we_n || re_n));

  // R7
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> !dq_oe);

  // R5
  latch_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n) (cle || ale) |-> !ce_n);

  // R4
  data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(dq_out));

  // R8
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> ##2 rd_valid);

  // R8
  rd_valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cap_evt, 2));

  // R11
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_active |=> ce_n);

  // R10
  no_start_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !req_ready) |=> ce_n);

endmodule

bind nand_bus_seq nbs_checker #(.DQ_W(DQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
  .we_n(nand_we_n), .re_n(nand_re_n), .dq_oe(nand_dq_oe), .dq_out(nand_dq_out),
  .req_ready(req_ready), .rd_valid(rd_valid), .cap_evt(cap_evt),
  .bank_active(bank_active)
);

// File: tb/nand_bus_seq_tb.sv
`timescale 1ns/1ps
module nand_bus_seq_tb;

  localparam int KC = 1, KA = 2, KW = 3, KR = 4;

  typedef struct {
    int          kind;
    int          pre;
    int          setup;
    int          strobe;
    int          hold;
    logic [15:0] data;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        cmd_valid = 1'b0, addr_valid = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
  logic [7:0]  cmd_byte = '0, addr_byte = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] nand_dq_in = '0;
  logic        nand_rb = 1'b1;
  logic        req_ready, rd_valid, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [15:0] rd_data, nand_dq_out;

  int n_vec = 0, n_bad = 0;
  bit mon_en = 1'b1;
  rec_t exp_q[$];
  logic [15:0] rdq[$];

  int b_tset, b_twait, b_thold, b_thiz, b_tclr, b_tar, b_wide, b_last;

  always #2.5 clk = ~clk;

  nand_bus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .addr_valid(addr_valid), .addr_byte(addr_byte),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input bit sel, input logic [31:0] v);
    @(negedge clk);
    cfg_sel = sel; cfg_wdata = v; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_timing(input int s, input int w, input int h, input int z);
    b_tset = s; b_twait = w; b_thold = h; b_thiz = z;
    cfg(1'b1, {z[7:0], h[7:0], w[7:0], s[7:0]});
  endtask

  task automatic set_ctrl(input bit srst, input bit wt, input bit en, input bit typ, input bit wide);
    logic [31:0] v;
    b_wide = wide;
    v = 32'(srst) | (32'(wt) << 1) | (32'(en) << 2) | (32'(typ) << 3) | (32'(wide) << 4)
      | (32'(b_tclr) << 9) | (32'(b_tar) << 13);
    cfg(1'b0, v);
  endtask

  // Expected pin record, built from the programmed fields and the previous access type.
  function automatic rec_t model(input int k, input logic [15:0] d);
    rec_t r;
    int lead;
    lead = 0;
    if (k == KR && b_last == KC) lead = b_tclr + 1;
    if (k == KR && b_last == KA) lead = b_tar + 1;
    if (k != KR && b_last == KR) lead = b_thiz;
    r.kind   = k;
    r.pre    = (k == KR) ? lead + b_tset + 1 : lead;
    r.setup  = (k == KR) ? 0 : b_tset + 1;
    r.strobe = b_twait + 1;
    r.hold   = (b_thold < 1) ? 1 : b_thold;
    if (k == KC || k == KA) r.data = {8'h00, d[7:0]};
    else if (k == KW)       r.data = b_wide ? d : {8'h00, d[7:0]};
    else                    r.data = 16'h0000;
    return r;
  endfunction

  task automatic drive_req(input int k, input logic [15:0] d, input bit on);
    cmd_valid = on && k == KC; addr_valid = on && k == KA;
    wr_valid = on && k == KW; rd_req = on && k == KR;
    cmd_byte = d[7:0]; addr_byte = d[7:0]; wr_data = d;
  endtask

  task automatic issue(input int k, input logic [15:0] d, input logic [15:0] flash, input bit expect_it);
    if (expect_it) begin
      exp_q.push_back(model(k, d));
      if (k == KR) rdq.push_back(b_wide ? flash : {8'h00, flash[7:0]});
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    nand_dq_in = flash;
    drive_req(k, d, 1'b1);
    @(negedge clk);
    drive_req(k, d, 1'b0);
    b_last = k;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((exp_q.size() != 0 || rdq.size() != 0) && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  // Monitor: measure each access from the pins and compare with the queued record.
  int m_pre, m_set, m_str, m_hold, m_kind;
  bit m_in, m_saw, m_rv, prev_re = 1'b1;
  logic [15:0] m_data;
  always @(negedge clk) begin
    if (m_rv) begin
      if (rdq.size() == 0) chk(1'b0, "R8 spurious read", 0, 0);
      else begin
        logic [15:0] e;
        e = rdq.pop_front();
        chk(rd_valid === 1'b1, "R8 rd_valid pulse", rd_valid, 1);
        chk(rd_data === e, "R8/R9 rd_data", rd_data, e);
      end
    end else if (rst_n && rd_valid === 1'b1) begin
      chk(1'b0, "R8 unexpected rd_valid", 1, 0);
    end
    m_rv = mon_en && prev_re == 1'b0 && nand_re_n == 1'b1;
    prev_re = nand_re_n;
    if (rst_n && nand_ce_n == 1'b0) begin
      if (!m_in) begin
        m_in = 1; m_saw = 0; m_pre = 0; m_set = 0; m_str = 0; m_hold = 0; m_kind = 0; m_data = '0;
      end
      if (!nand_we_n || !nand_re_n) begin
        m_str++; m_saw = 1;
        if (!nand_re_n) m_kind = KR;
        else begin
          m_kind = nand_cle ? KC : (nand_ale ? KA : KW);
          m_data = nand_dq_out;
        end
      end else if (!m_saw) begin
        if (nand_cle || nand_ale || nand_dq_oe) m_set++;
        else m_pre++;
      end else m_hold++;
    end else if (m_in) begin
      m_in = 0;
      if (mon_en) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected access", m_kind, 0);
        else begin
          rec_t e;
          e = exp_q.pop_front();
          chk(m_kind == e.kind, "R5 access type", m_kind, e.kind);
          chk(m_pre == e.pre, "R6/R7 lead-in cycles", m_pre, e.pre);
          chk(m_set == e.setup, "R2 setup cycles", m_set, e.setup);
          chk(m_str == e.strobe, "R3 strobe cycles", m_str, e.strobe);
          chk(m_hold == e.hold, "R4 hold cycles", m_hold, e.hold);
          if (e.kind != KR) chk(m_data === e.data, "R5/R9 bus data", m_data, e.data);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    b_last = 0; b_wide = 0; b_tclr = 1; b_tar = 4;
    b_tset = 0; b_twait = 0; b_thold = 0; b_thiz = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes idle in reset", {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
    chk(!nand_cle && !nand_ale && !nand_dq_oe, "R1 latches and oe low", {nand_cle, nand_ale, nand_dq_oe}, 0);
    chk(!req_ready && !rd_valid, "R1 ready/valid low", {req_ready, rd_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!req_ready, "R1 not ready before enable", req_ready, 0);

    set_timing(2, 3, 2, 3);
    set_ctrl(0, 0, 1, 0, 1);
    @(negedge clk);
    chk(!req_ready, "R1 needs NAND select", req_ready, 0);
    set_ctrl(0, 0, 1, 1, 1);
    @(negedge clk);
    chk(req_ready, "R1 ready when enabled", req_ready, 1);

    // R2 R3 R4 R5 R6 R7 R8: mixed sequence
    issue(KC, 16'h0070, 0, 1);
    issue(KA, 16'h0012, 0, 1);
    issue(KR, 0, 16'hC3A5, 1);
    issue(KR, 0, 16'h1E2D, 1);
    issue(KW, 16'h1234, 0, 1);
    issue(KC, 16'h0090, 0, 1);
    issue(KR, 0, 16'h5A5A, 1);
    issue(KC, 16'h00FF, 0, 1);
    drain();

    // R4 zero hold taken as one, minimum setup and wait; R7 zero turnaround
    set_timing(0, 0, 0, 0);
    issue(KW, 16'hBEEF, 0, 1);
    issue(KR, 0, 16'h0F0F, 1);
    issue(KA, 16'h0033, 0, 1);
    drain();

    // R9 narrow bus
    set_timing(1, 1, 1, 1);
    set_ctrl(0, 0, 1, 1, 0);
    issue(KW, 16'hA55A, 0, 1);
    issue(KR, 0, 16'hBEEF, 1);
    drain();

    // R10 stall while busy with wait enabled
    set_ctrl(0, 1, 1, 1, 1);
    nand_rb = 1'b0;
    repeat (4) @(negedge clk);
    chk(!req_ready, "R10 not ready while busy", req_ready, 0);
    exp_q.push_back(model(KW, 16'h4321));
    drive_req(KW, 16'h4321, 1'b1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(nand_ce_n, "R10 no start while busy", nand_ce_n, 1);
    end
    nand_rb = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    drive_req(KW, 16'h4321, 1'b0);
    b_last = KW;
    drain();
    // R10 busy ignored with wait disabled
    set_ctrl(0, 0, 1, 1, 1);
    nand_rb = 1'b0;
    repeat (4) @(negedge clk);
    issue(KC, 16'h00AB, 0, 1);
    drain();
    nand_rb = 1'b1;

    // R5 priority: command wins over a simultaneous read
    exp_q.push_back(model(KC, 16'h0031));
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cmd_byte = 8'h31; cmd_valid = 1'b1; rd_req = 1'b1; wr_valid = 1'b1; wr_data = 16'h7777;
    @(negedge clk);
    cmd_valid = 1'b0; rd_req = 1'b0; wr_valid = 1'b0;
    b_last = KC;
    drain();

    // R11 abort by clearing enable
    set_timing(1, 60, 1, 1);
    mon_en = 1'b0;
    issue(KW, 16'h0F00, 0, 0);
    repeat (5) @(negedge clk);
    chk(!nand_ce_n, "R11 access in progress", nand_ce_n, 0);
    set_ctrl(0, 0, 0, 1, 1);
    @(negedge clk);
    chk(nand_ce_n, "R11 CE high after disable", nand_ce_n, 1);
    chk(!req_ready, "R11 not ready when disabled", req_ready, 0);
    repeat (5) @(negedge clk);
    chk(nand_ce_n && nand_we_n, "R11 bus stays idle", {nand_ce_n, nand_we_n}, 3);
    mon_en = 1'b1;
    set_timing(2, 2, 1, 2);
    set_ctrl(0, 0, 1, 1, 1);

    // R12 soft reset holds idle and forgets the previous type
    issue(KC, 16'h0060, 0, 1);
    drain();
    set_ctrl(1, 0, 1, 1, 1);
    @(negedge clk);
    chk(!req_ready, "R12 not ready in soft reset", req_ready, 0);
    set_ctrl(0, 0, 1, 1, 1);
    b_last = 0;
    issue(KR, 0, 16'h6E6E, 1);
    drain();

    chk(exp_q.size() == 0 && rdq.size() == 0, "R5 all accesses seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule